// File: doc/BRIEF.md
# Interrupt Source Priority Arbiter

This block decides which pending interrupt source a processor core services when it finishes an instruction. It watches six sources: a divide fault, a software interrupt instruction carrying its own 8-bit type, an overflow trap instruction, a non-maskable request pin, a maskable request pin, and the single-step trap. The core pulses an end-of-instruction strobe. In that cycle the arbiter evaluates the sources in a fixed order. On the next clock edge it registers one winner as a one-cycle take pulse, together with the 8-bit type of the winner.

Each source has its own sensitivity. The non-maskable pin is edge sensitive: a rising edge is latched and held until it is serviced, so it survives being outranked. The maskable pin is level sensitive and only counts while the interrupt-enable flag is set. The overflow trap instruction only counts while the overflow flag is set. The single-step trap only counts while the trap flag is set. When the maskable pin wins, the arbiter does not supply a type. It raises an external-type-fetch flag instead, and the core then obtains the type through an acknowledge cycle that lies outside this block.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, `take`, `ext_fetch` and `take_type` are all 0, and no non-maskable request is pending.
- R2: `take` is high only in the cycle after a cycle in which `boundary` was high and at least one source was active. Outside that case it stays low.
- R3: When several sources are active in the same boundary cycle, the winner follows this order, highest first: divide fault, software interrupt, overflow trap, non-maskable, maskable, single step.
- R4: The type of the winner is 0x00 for a divide fault, the value of `swi_type` for a software interrupt, 0x04 for an overflow trap, 0x02 for a non-maskable request and 0x01 for single step.
- R5: A rising edge on `nmi_pin` is a 0-to-1 change between two consecutive clock samples (the sample before the first one after reset counts as 0). Each such edge produces exactly one service, at the first boundary where no higher source wins. If the pin is held high, no further service follows.
- R6: The maskable pin is a source only while both `intr_pin` and `if_flag` are 1. With `if_flag` at 0 it has no effect on the outputs.
- R7: An overflow trap instruction with `of_flag` at 0 has no effect. Arbitration then proceeds as if that source were absent.
- R8: When the maskable pin wins, `ext_fetch` is 1 and `take_type` is 0x00. In every other case `ext_fetch` is 0.
- R9: While `take` is low, `take_type` is 0x00 and `ext_fetch` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | End-of-instruction strobe; sources are evaluated in this cycle |
| div_err | input | 1 | Divide fault raised by the instruction that just finished |
| swi_req | input | 1 | A software interrupt instruction just finished |
| swi_type | input | 8 | Type carried by the software interrupt instruction |
| ovf_trap | input | 1 | An overflow trap instruction just finished |
| nmi_pin | input | 1 | Non-maskable request pin, rising-edge sensitive |
| intr_pin | input | 1 | Maskable request pin, active-high level |
| if_flag | input | 1 | Interrupt-enable flag |
| tf_flag | input | 1 | Trap (single-step) flag |
| of_flag | input | 1 | Overflow flag |
| take | output | 1 | One-cycle pulse: an interrupt is to be serviced |
| take_type | output | 8 | Type of the selected source |
| ext_fetch | output | 1 | The type must be fetched externally (maskable pin won) |

## Verification
The main function is tested with random mixes in which several sources are active at once. These mixes separate a correct fixed order from an order in which two neighbouring levels are swapped. Directed patterns isolate the gated sources: the maskable pin with the enable flag clear, and the overflow trap with the overflow flag clear. In both cases a lower source must win instead, or nothing at all. Another directed pattern raises a non-maskable edge together with a divide fault, then keeps the pin high across later boundaries. This shows that the latch holds the request until it is served and that a steady level does not re-fire it. Boundary-low cycles with all sources active confirm that nothing is taken between instructions.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int TW = 8,
  parameter logic [TW-1:0] DIV_TYPE  = 8'h00,
  parameter logic [TW-1:0] STEP_TYPE = 8'h01,
  parameter logic [TW-1:0] NMI_TYPE  = 8'h02,
  parameter logic [TW-1:0] OVF_TYPE  = 8'h04
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary,
  input  logic          div_err,
  input  logic          swi_req,
  input  logic [TW-1:0] swi_type,
  input  logic          ovf_trap,
  input  logic          nmi_pin,
  input  logic          intr_pin,
  input  logic          if_flag,
  input  logic          tf_flag,
  input  logic          of_flag,
  output logic          take,
  output logic [TW-1:0] take_type,
  output logic          ext_fetch
);

  logic nmi_q, nmi_pend;

  wire nmi_rise = nmi_pin & ~nmi_q;
  wire nmi_hit  = nmi_pend | nmi_rise;
  wire ovf_hit  = ovf_trap & of_flag;
  wire intr_hit = intr_pin & if_flag;

  logic          sel_any, sel_fetch, sel_nmi;
  logic [TW-1:0] sel_type;

  always_comb begin
    sel_any   = 1'b1;
    sel_fetch = 1'b0;
    sel_nmi   = 1'b0;
    sel_type  = '0;
    if (div_err)       sel_type = DIV_TYPE;
    else if (swi_req)  sel_type = swi_type;
    else if (ovf_hit)  sel_type = OVF_TYPE;
    else if (nmi_hit)  begin sel_type = NMI_TYPE; sel_nmi = 1'b1; end
    else if (intr_hit) sel_fetch = 1'b1;
    else if (tf_flag)  sel_type = STEP_TYPE;
    else               sel_any = 1'b0;
  end

  wire fire = boundary & sel_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q     <= 1'b0;
      nmi_pend  <= 1'b0;
      take      <= 1'b0;
      take_type <= '0;
      ext_fetch <= 1'b0;
    end else begin
      nmi_q     <= nmi_pin;
      nmi_pend  <= nmi_hit & ~(fire & sel_nmi);
      take      <= fire;
      take_type <= fire ? sel_type : '0;
      ext_fetch <= fire & sel_fetch;
    end
  end

endmodule

module irq_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       boundary,
  input logic       div_err,
  input logic       intr_pin,
  input logic       if_flag,
  input logic       take,
  input logic [7:0] take_type,
  input logic       ext_fetch
);
  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  assert_take_after_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && take |-> $past(boundary));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> (take_type == 8'h00) && !ext_fetch);

  assert_fetch_type_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_fetch |-> take && (take_type == 8'h00));

  assert_fetch_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    armed && ext_fetch |-> $past(intr_pin && if_flag));

  assert_divide_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(boundary && div_err) |-> take && (take_type == 8'h00) && !ext_fetch);
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .div_err(div_err),
  .intr_pin(intr_pin), .if_flag(if_flag), .take(take),
  .take_type(take_type), .ext_fetch(ext_fetch)
);

// File: tb/irq_arbiter_bench.sv
module irq_arbiter_bench;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boundary = 0, div_err = 0, swi_req = 0, ovf_trap = 0;
  logic nmi_pin = 0, intr_pin = 0, if_flag = 0, tf_flag = 0, of_flag = 0;
  logic [7:0] swi_type = 0;
  logic take, ext_fetch;
  logic [7:0] take_type;

  int checks = 0, errors = 0;
  bit m_prev = 0, m_pend = 0;

  always #(PERIOD/2) clk = ~clk;

  irq_arbiter u_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .div_err(div_err),
    .swi_req(swi_req), .swi_type(swi_type), .ovf_trap(ovf_trap),
    .nmi_pin(nmi_pin), .intr_pin(intr_pin), .if_flag(if_flag),
    .tf_flag(tf_flag), .of_flag(of_flag), .take(take),
    .take_type(take_type), .ext_fetch(ext_fetch)
  );

  // Expected outputs: {take, fetch, type}, from R3/R4/R6/R7/R8
  function automatic logic [9:0] expect_out(bit nmi_hit);
    if (!boundary)                return 10'h000;
    if (div_err)                  return {2'b10, 8'h00};
    if (swi_req)                  return {2'b10, swi_type};
    if (ovf_trap && of_flag)      return {2'b10, 8'h04};
    if (nmi_hit)                  return {2'b10, 8'h02};
    if (intr_pin && if_flag)      return {2'b11, 8'h00};
    if (tf_flag)                  return {2'b10, 8'h01};
    return 10'h000;
  endfunction

  task automatic step(string tag);
    bit hit;
    logic [9:0] e;
    hit = m_pend || (nmi_pin && !m_prev);
    e = expect_out(hit);
    m_pend = hit && !(e[9] && !e[8] && e[7:0] == 8'h02 && boundary && !div_err
                      && !swi_req && !(ovf_trap && of_flag));
    m_prev = nmi_pin;
    @(posedge clk); #1;
    checks++;
    if ({take, ext_fetch, take_type} !== e) begin
      errors++;
      $display("FAIL %s: got take=%0b fetch=%0b type=%02h expected take=%0b fetch=%0b type=%02h",
               tag, take, ext_fetch, take_type, e[9], e[8], e[7:0]);
    end
    @(negedge clk);
  endtask

  task automatic clear();
    boundary = 0; div_err = 0; swi_req = 0; ovf_trap = 0;
    intr_pin = 0; if_flag = 0; tf_flag = 0; of_flag = 0; swi_type = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    checks++;
    if (take !== 0 || ext_fetch !== 0 || take_type !== 0) begin
      errors++;
      $display("FAIL R1: got %0b %0b %02h expected 0 0 00", take, ext_fetch, take_type);
    end
    boundary = 1; step("R1");                         // nothing pending after reset
    // R2: all sources but no boundary
    boundary = 0; div_err = 1; swi_req = 1; tf_flag = 1; intr_pin = 1; if_flag = 1;
    step("R2");
    clear();
    // R5: NMI edge outranked by divide fault, then served once, then held high
    nmi_pin = 1; boundary = 1; div_err = 1; step("R5");
    div_err = 0; step("R5");
    step("R5");
    boundary = 0; step("R5");
    boundary = 1; tf_flag = 1; step("R5");
    clear(); nmi_pin = 0; step("R5");
    // R6: maskable pin with enable low
    boundary = 1; intr_pin = 1; if_flag = 0; step("R6");
    if_flag = 1; step("R8");
    tf_flag = 1; if_flag = 0; step("R6");
    clear();
    // R7: overflow trap with OF clear
    boundary = 1; ovf_trap = 1; of_flag = 0; step("R7");
    tf_flag = 1; step("R7");
    of_flag = 1; step("R4");
    clear();
    // R4: breakpoint-style software type and explicit types
    boundary = 1; swi_req = 1; swi_type = 8'h03; step("R4");
    swi_type = 8'hff; ovf_trap = 1; of_flag = 1; step("R3");
    clear();
    // R3 random mixes
    for (int i = 0; i < 3000; i++) begin
      boundary = ($urandom % 4) != 0;
      div_err  = ($urandom % 8) == 0;
      swi_req  = ($urandom % 6) == 0;
      swi_type = 8'($urandom);
      ovf_trap = ($urandom % 5) == 0;
      of_flag  = $urandom % 2;
      if (($urandom % 4) == 0) nmi_pin = ~nmi_pin;
      intr_pin = ($urandom % 3) == 0;
      if_flag  = $urandom % 2;
      tf_flag  = ($urandom % 3) == 0;
      step("R3");
    end
    clear(); nmi_pin = 0;
    boundary = 1; step("R9");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule